// File: doc/BRIEF.md
# Microsequenced Accumulator Processor

This block is a small 8-bit processor built around one accumulator. Each instruction is a single byte that packs a 4-bit operation code with a 4-bit operand address. Program and data share one 16-byte memory, which sits outside the block. The processor presents an address and reads the byte back combinationally. Inside are a program counter, an instruction register, the accumulator, an operand latch, an output register and a zero/carry flag pair. An add/subtract unit computes results. A five-state timing sequencer drives every load, select and write.

The host drives a step enable. Holding it high runs the program at one timing state per clock. Pulsing it advances the program one state at a time. When it is low, all state is held. The host reads results from the output register and watches the halt flag. After a halt instruction the processor stays frozen until reset.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter, accumulator, operand latch, output register, both flags and the timing state to zero, so that `mem_addr` is 0, `out_val` is 0 and `halted` is low.
- R2: The opcode is bits [7:4] of an instruction and the operand address is bits [3:0]. In states T0 and T1 `mem_addr` is the program counter. At the end of T1 the instruction register takes `mem_rdata` and the program counter increments. In T2 and T3 of a memory instruction `mem_addr` is the operand address.
- R3: Opcode 0x0 (load) copies the addressed byte into the accumulator. It uses states T0 to T4 and leaves both flags unchanged.
- R4: Opcode 0x1 (add) sets the accumulator to accumulator plus the addressed byte, modulo 256. Carry is set to the carry out, and zero is set when the result is 0. It uses T0 to T4.
- R5: Opcode 0x2 (subtract) sets the accumulator to accumulator minus the addressed byte, modulo 256. Carry is set to 1 when no borrow occurred (accumulator >= operand), and zero is set when the result is 0. It uses T0 to T4.
- R6: Opcode 0xE (output) copies the accumulator into `out_val` at the end of T2. It uses T0 to T2, so a program that loads 0x64 and then adds 0x32 and 0x68 outputs 0xFE.
- R7: Opcode 0xF (halt) raises `halted` at the end of its T2. From then on, `mem_addr`, `out_val`, the flags and `halted` stay unchanged until reset.
- R8: Every other opcode is a no-op. It uses T0 to T2 and changes only the program counter.
- R9: While `step_en` is low, no state changes. Each clock with `step_en` high advances the machine by exactly one timing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance one timing state on this clock |
| mem_rdata | input | 8 | Byte read from the shared memory at `mem_addr` |
| mem_addr | output | 4 | Address driven to the shared memory |
| out_val | output | 8 | Output register value |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry flag (no-borrow on subtract) |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest situation to reach from the ports is a pause that falls in the middle of an instruction's execute states. The sequencer then sits with the operand address on the bus and a partly built result. A held state that drifts shows up only as a wrong final result or a shifted cycle count. The bench runs the three-number sum program to the T2 of the first add, drops the step enable for many clocks, and checks that the address and output do not move. It then resumes and requires both the exact final value and the exact number of remaining enabled clocks. Flag retention across a load is reached by a program that adds with overflow before it loads a non-zero byte.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LDA = 4'h0,
        OP_ADD = 4'h1,
        OP_SUB = 4'h2,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        TS_0 = 3'd0,
        TS_1 = 3'd1,
        TS_2 = 3'd2,
        TS_3 = 3'd3,
        TS_4 = 3'd4
    } tstate_e;

    typedef struct packed {
        logic pc_inc;
        logic ir_we;
        logic b_ld;
        logic a_ld;
        logic a_from_alu;
        logic alu_sub;
        logic flags_we;
        logic out_we;
        logic halt_set;
        logic addr_opnd;
    } ctrl_t;

    function automatic logic uses_operand(opcode_e op);
        return (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic tstate_e final_state(opcode_e op);
        return uses_operand(op) ? TS_4 : TS_2;
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         carry,
    output logic         zero
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        y     = sum[W-1:0];
        carry = sum[W];
        zero  = (sum[W-1:0] == '0);
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [OPC_W-1:0] opcode,
    output tstate_e          tstate,
    output logic             halted,
    output ctrl_t            ctrl
);
    logic    adv;
    opcode_e op;
    tstate_e ts_next;
    ctrl_t   raw;

    assign adv = step_en && !halted;
    assign op  = opcode_e'(opcode);

    always_comb begin
        if (tstate == final_state(op))
            ts_next = TS_0;
        else
            ts_next = tstate_e'(3'(tstate + 3'd1));
    end

    always_comb begin
        raw = '0;
        raw.addr_opnd = uses_operand(op) && ((tstate == TS_2) || (tstate == TS_3));
        case (tstate)
            TS_1: begin
                raw.ir_we  = 1'b1;
                raw.pc_inc = 1'b1;
            end
            TS_2: begin
                raw.out_we   = (op == OP_OUT);
                raw.halt_set = (op == OP_HLT);
            end
            TS_3: begin
                raw.b_ld = uses_operand(op);
            end
            TS_4: begin
                raw.a_ld       = 1'b1;
                raw.a_from_alu = (op != OP_LDA);
                raw.alu_sub    = (op == OP_SUB);
                raw.flags_we   = (op != OP_LDA);
            end
            default: ;
        endcase
    end

    always_comb begin
        if (adv) begin
            ctrl = raw;
        end else begin
            ctrl = '0;
            ctrl.addr_opnd = raw.addr_opnd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tstate <= TS_0;
            halted <= 1'b0;
        end else if (adv) begin
            tstate <= ts_next;
            if (raw.halt_set)
                halted <= 1'b1;
        end
    end
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] breg,
    output logic [DATA_W-1:0] out_reg,
    output logic              zf,
    output logic              cf
);
    logic [DATA_W-1:0] alu_y;
    logic              alu_c;
    logic              alu_z;

    acc_alu #(.W(DATA_W)) u_alu (
        .a     (acc),
        .b     (breg),
        .sub   (ctrl.alu_sub),
        .y     (alu_y),
        .carry (alu_c),
        .zero  (alu_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ir      <= '0;
            acc     <= '0;
            breg    <= '0;
            out_reg <= '0;
            zf      <= 1'b0;
            cf      <= 1'b0;
        end else begin
            if (ctrl.pc_inc)
                pc <= pc + 1'b1;
            if (ctrl.ir_we)
                ir <= mem_rdata;
            if (ctrl.b_ld)
                breg <= mem_rdata;
            if (ctrl.a_ld)
                acc <= ctrl.a_from_alu ? alu_y : breg;
            if (ctrl.flags_we) begin
                zf <= alu_z;
                cf <= alu_c;
            end
            if (ctrl.out_we)
                out_reg <= acc;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] out_val,
    output logic              zero_flag,
    output logic              carry_flag,
    output logic              halted
);
    ctrl_t             ctrl;
    tstate_e           tstate;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] b_q;

    acc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .opcode  (ir_q[DATA_W-1 -: OPC_W]),
        .tstate  (tstate),
        .halted  (halted),
        .ctrl    (ctrl)
    );

    acc_dpath #(.ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .pc        (pc_q),
        .ir        (ir_q),
        .acc       (acc_q),
        .breg      (b_q),
        .out_reg   (out_val),
        .zf        (zero_flag),
        .cf        (carry_flag)
    );

    assign mem_addr = ctrl.addr_opnd ? ir_q[ADDR_W-1:0] : pc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DATA_W = OPC_W + ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] out_val,
    input logic              zero_flag,
    input logic              carry_flag,
    input logic              halted,
    input tstate_e           tstate,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] acc,
    input logic [DATA_W-1:0] breg
);
    logic [OPC_W-1:0] opc;
    logic             live;
    assign opc  = ir[DATA_W-1 -: OPC_W];
    assign live = step_en && !halted;

    p_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (live && tstate == TS_1) |=> (ir == $past(mem_rdata)) && (pc == $past(pc) + 1'b1));

    p_lda_r3: assert property (@(posedge clk) disable iff (rst)
        (live && tstate == TS_4 && opc == OP_LDA)
        |=> (acc == $past(breg)) && $stable(zero_flag) && $stable(carry_flag));

    p_add_r4: assert property (@(posedge clk) disable iff (rst)
        (live && tstate == TS_4 && opc == OP_ADD)
        |=> ({carry_flag, acc} == ({1'b0, $past(acc)} + {1'b0, $past(breg)}))
            && (zero_flag == (acc == '0)));

    p_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (live && tstate == TS_4 && opc == OP_SUB)
        |=> (acc == DATA_W'($past(acc) - $past(breg)))
            && (carry_flag == ($past(acc) >= $past(breg)))
            && (zero_flag == (acc == '0)));

    p_out_t2_r6: assert property (@(posedge clk) disable iff (rst)
        (live && tstate == TS_2 && opc == OP_OUT) |=> (out_val == $past(acc)));

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(out_val) && $stable(mem_addr)
                   && $stable(zero_flag) && $stable(carry_flag));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(out_val) && $stable(mem_addr) && $stable(halted)
                     && $stable(acc) && $stable(tstate));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .out_val    (out_val),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .halted     (halted),
    .tstate     (tstate),
    .pc         (pc_q),
    .ir         (ir_q),
    .acc        (acc_q),
    .breg       (b_q)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [7:0] mem_rdata;
    logic [3:0] mem_addr;
    logic [7:0] out_val;
    logic       zero_flag;
    logic       carry_flag;
    logic       halted;

    logic [7:0] mem [16];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    assign mem_rdata = mem[mem_addr];

    acc_cpu dut (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .out_val    (out_val),
        .zero_flag  (zero_flag),
        .carry_flag (carry_flag),
        .halted     (halted)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_en = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input int limit, output int n);
        n = 0;
        while (!halted && n < limit) begin
            tick(1);
            n++;
        end
    endtask

    // Three-number sum, fetch timing and halt freeze
    task automatic t_sum3();
        int n;
        clear_mem();
        mem[0] = 8'h06; mem[1] = 8'h17; mem[2] = 8'h18;
        mem[3] = 8'hE0; mem[4] = 8'hF0;
        mem[6] = 8'h64; mem[7] = 8'h32; mem[8] = 8'h68;
        do_reset();
        chk(mem_addr == 4'h0 && out_val == 8'h00 && !halted, "R1 reset addr/out/halt",
            {mem_addr, out_val, 3'b0, halted}, 0);
        chk(!zero_flag && !carry_flag, "R1 reset flags", {zero_flag, carry_flag}, 0);
        tick(1);
        chk(mem_addr == 4'h0, "R2 T1 address is PC", mem_addr, 0);
        tick(1);
        chk(mem_addr == 4'h6, "R2 T2 address is operand", mem_addr, 6);
        tick(2);
        chk(mem_addr == 4'h1, "R2 T4 address is incremented PC", mem_addr, 1);
        tick(1);
        chk(mem_addr == 4'h1, "R2 next T0 address", mem_addr, 1);
        run_to_halt(100, n);
        chk(n == 16, "R6 remaining clocks for sum program", n, 16);
        chk(out_val == 8'hFE, "R6 sum output", out_val, 8'hFE);
        chk(!zero_flag && !carry_flag, "R4 flags after sum", {zero_flag, carry_flag}, 0);
        tick(30);
        chk(halted && out_val == 8'hFE, "R7 output frozen after halt", out_val, 8'hFE);
        chk(mem_addr == 4'h5, "R7 address frozen after halt", mem_addr, 5);
    endtask

    // Pause inside an add's execute states
    task automatic t_pause();
        int n;
        logic [3:0] a0;
        do_reset();
        tick(7);
        a0 = mem_addr;
        chk(a0 == 4'h7, "R9 paused at add operand", a0, 7);
        step_en = 1'b0;
        tick(25);
        chk(mem_addr == a0 && out_val == 8'h00 && !halted, "R9 hold address/out",
            mem_addr, a0);
        step_en = 1'b1;
        run_to_halt(100, n);
        chk(n == 14, "R9 remaining clocks after pause", n, 14);
        chk(out_val == 8'hFE, "R9 result after pause", out_val, 8'hFE);
    endtask

    // Subtract cases
    task automatic t_sub(input logic [7:0] x, input logic [7:0] y);
        int n;
        logic [7:0] d;
        d = x - y;
        clear_mem();
        mem[0] = 8'h06; mem[1] = 8'h27; mem[2] = 8'hE0; mem[3] = 8'hF0;
        mem[6] = x; mem[7] = y;
        do_reset();
        run_to_halt(100, n);
        chk(n == 16, "R5 subtract program clocks", n, 16);
        chk(out_val == d, "R5 difference", out_val, d);
        chk(carry_flag == (x >= y), "R5 no-borrow carry", carry_flag, x >= y);
        chk(zero_flag == (d == 0), "R5 zero", zero_flag, d == 0);
    endtask

    // Overflowing add, then a load that must keep flags; then reset clears
    task automatic t_flags_keep();
        int n;
        clear_mem();
        mem[0] = 8'h06; mem[1] = 8'h17; mem[2] = 8'h08;
        mem[3] = 8'hE0; mem[4] = 8'hF0;
        mem[6] = 8'hFF; mem[7] = 8'h01; mem[8] = 8'h05;
        do_reset();
        tick(10);
        chk(zero_flag && carry_flag, "R4 overflow add sets Z and C",
            {zero_flag, carry_flag}, 3);
        run_to_halt(100, n);
        chk(out_val == 8'h05, "R3 loaded value", out_val, 5);
        chk(zero_flag && carry_flag, "R3 load keeps flags", {zero_flag, carry_flag}, 3);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk(out_val == 8'h00 && mem_addr == 4'h0 && !halted, "R1 reset after run",
            out_val, 0);
        chk(!zero_flag && !carry_flag, "R1 reset clears flags", {zero_flag, carry_flag}, 0);
    endtask

    // Unused opcode is a no-op; output timing
    task automatic t_nop();
        int n;
        clear_mem();
        mem[0] = 8'h05; mem[1] = 8'h53; mem[2] = 8'hE0; mem[3] = 8'hF0;
        mem[5] = 8'h3C;
        do_reset();
        tick(8);
        chk(mem_addr == 4'h2, "R8 no-op advances PC after three states", mem_addr, 2);
        tick(2);
        chk(out_val == 8'h00, "R6 output not yet written before T2 edge", out_val, 0);
        tick(1);
        chk(out_val == 8'h3C, "R8 no-op left accumulator", out_val, 8'h3C);
        run_to_halt(100, n);
        chk(n == 3, "R7 halt takes three states", n, 3);
        chk(!zero_flag && !carry_flag, "R8 no-op leaves flags", {zero_flag, carry_flag}, 0);
    endtask

    initial begin
        tick(1);
        t_sum3();
        t_pause();
        t_sub(8'h05, 8'h05);
        t_sub(8'h03, 8'h05);
        t_sub(8'h90, 8'h21);
        t_flags_keep();
        t_nop();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule